// File: doc/BRIEF.md
# Output Power-Good Window Monitor

This block turns a stream of digitized regulator feedback samples into a power-good decision and an overvoltage guard. Four thresholds are derived from a programmable nominal code: a fault floor at 92 %, a release floor at 94 %, a release ceiling at 107 % and a fault ceiling at 109 % of nominal. The gap between each fault threshold and its release threshold gives hysteresis, so a sample sitting in that band keeps the present decision. The power-good result drives the pull-down of an open-drain pin. When the pin is not pulled down, an external resistor pulls it high.

An overvoltage sample also sets a mask that forces the high-side switch request low. The mask stays set until a later sample falls below the 107 % level. Only cycles that carry the sample-valid strobe can change any state. The high-side gate is combinational, so the raw PWM request is blocked in the same cycle the mask is seen.

Top module: `pgood_window_mon`

## Requirements
- R1: While reset is low and on the first cycle after it, `pg_pull_low` is 1 (fault) and `ov_flag` is 0.
- R2: A valid sample strictly below floor(nom×92/100) makes `pg_pull_low` 1 after the next clock edge.
- R3: A valid sample strictly above floor(nom×109/100) makes both `pg_pull_low` and `ov_flag` 1 after the next clock edge.
- R4: A valid sample in the inclusive range floor(nom×94/100) to floor(nom×107/100) makes `pg_pull_low` 0 after the next clock edge.
- R5: A valid sample inside a hysteresis band (from the 92 % floor up to just below the 94 % floor, or from just above the 107 % floor up to the 109 % floor) leaves `pg_pull_low` unchanged. It also leaves `ov_flag` unchanged, except that `ov_flag` clears if the sample is below the 107 % floor.
- R6: `ov_flag` clears only after a valid sample strictly below floor(nom×107/100). A sample equal to that level keeps the flag set.
- R7: `hs_drive` is 1 exactly when `hs_req` is 1 and `ov_flag` is 0, in the same cycle.
- R8: On a cycle with `smp_vld` low, neither `pg_pull_low` nor `ov_flag` changes, whatever the sample holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample-valid strobe |
| smp_code | input | SAMPLE_W | Feedback sample code |
| nom_code | input | SAMPLE_W | Nominal output code |
| hs_req | input | 1 | Raw high-side PWM request |
| pg_pull_low | output | 1 | 1 = pull the power-good pin low (fault) |
| ov_flag | output | 1 | Overvoltage mask active |
| hs_drive | output | 1 | Gated high-side drive |

## Verification
`pg_pull_low` and `ov_flag` are registered. They reflect a strobed sample one clock edge after that sample is presented, so the bench samples them 1 ns after that rising edge. `hs_drive` has no register. The bench checks it 1 ns after the inputs change on the falling edge, against the overvoltage state the model held before the coming edge. Samples are placed one code either side of every threshold, and a random sweep around nominal exercises the hysteresis bands and cycles with no strobe.

// File: rtl/pg_pkg.sv
// Shared constants and types for the power-good window monitor.
// Assumes thresholds are whole percentages of the nominal code.
package pg_pkg;
    localparam int unsigned NUM_THR      = 4;
    localparam int unsigned PCT_DIV      = 100;
    localparam int unsigned PCT_UV_FAULT = 92;
    localparam int unsigned PCT_UV_REL   = 94;
    localparam int unsigned PCT_OV_REL   = 107;
    localparam int unsigned PCT_OV_FAULT = 109;

    // Index of each threshold in the threshold vector
    typedef enum int unsigned {
        THR_UV_FAULT = 0,
        THR_UV_REL   = 1,
        THR_OV_REL   = 2,
        THR_OV_FAULT = 3
    } thr_idx_e;

    // Comparator results for one sample
    typedef struct packed {
        logic uv_trip;   // below the low fault floor
        logic ov_trip;   // above the high fault ceiling
        logic in_window; // inside the release window, inclusive
        logic ov_drop;   // strictly below the high release level
    } pg_cmp_t;

    // Percentage attached to each threshold index
    function automatic int unsigned thr_pct(input int unsigned idx);
        case (idx)
            THR_UV_FAULT: return PCT_UV_FAULT;
            THR_UV_REL:   return PCT_UV_REL;
            THR_OV_REL:   return PCT_OV_REL;
            default:      return PCT_OV_FAULT;
        endcase
    endfunction
endpackage

// File: rtl/pg_thresh_calc.sv
// Derives the four window thresholds from the nominal code.
// Each threshold is floor(nom * pct / 100). The widths leave room for 109 %.
module pg_thresh_calc
    import pg_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0]                nom_code,
    output logic [NUM_THR-1:0][SAMPLE_W:0]     thr
);
    localparam int unsigned THR_W  = SAMPLE_W + 1;
    localparam int unsigned PROD_W = SAMPLE_W + 7;

    for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_thr
        localparam int unsigned PCT = thr_pct(gi);
        logic [PROD_W-1:0] prod;
        // Scale the nominal code by this threshold's percentage
        always_comb begin
            prod     = PROD_W'(nom_code) * PROD_W'(PCT);
            thr[gi]  = THR_W'(prod / PROD_W'(PCT_DIV));
        end
    end
endmodule

// File: rtl/pg_window_cmp.sv
// Compares one sample against the four thresholds.
// Assumes the threshold vector comes from pg_thresh_calc.
module pg_window_cmp
    import pg_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0]            smp_code,
    input  logic [NUM_THR-1:0][SAMPLE_W:0] thr,
    output pg_cmp_t                        cmp
);
    logic [SAMPLE_W:0] smp_ext;

    // Classify the sample against every threshold
    always_comb begin
        smp_ext       = {1'b0, smp_code};
        cmp.uv_trip   = smp_ext < thr[THR_UV_FAULT];
        cmp.ov_trip   = smp_ext > thr[THR_OV_FAULT];
        cmp.in_window = (smp_ext >= thr[THR_UV_REL]) && (smp_ext <= thr[THR_OV_REL]);
        cmp.ov_drop   = smp_ext < thr[THR_OV_REL];
    end
endmodule

// File: rtl/pg_state_ctl.sv
// Holds the power-good decision and the overvoltage mask.
// Changes only on strobed cycles. Reset gives fault with the mask clear.
module pg_state_ctl
    import pg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    smp_vld,
    input  pg_cmp_t cmp,
    output logic    pg_good,
    output logic    ov_mask
);
    typedef enum logic {PG_FAULT = 1'b0, PG_OK = 1'b1} pg_state_e;
    pg_state_e state_q, state_d;
    logic      mask_d;

    // Next-state choice with hysteresis; states between thresholds hold
    always_comb begin
        state_d = state_q;
        mask_d  = ov_mask;
        if (smp_vld) begin
            if (state_q == PG_OK) begin
                if (cmp.uv_trip || cmp.ov_trip) state_d = PG_FAULT;
            end else if (cmp.in_window) begin
                state_d = PG_OK;
            end
            if (cmp.ov_trip)      mask_d = 1'b1;
            else if (cmp.ov_drop) mask_d = 1'b0;
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PG_FAULT;
            ov_mask <= 1'b0;
        end else begin
            state_q <= state_d;
            ov_mask <= mask_d;
        end
    end

    assign pg_good = (state_q == PG_OK);
endmodule

// File: rtl/pgood_window_mon.sv
// Top of the power-good window monitor.
// Assumes smp_code and nom_code share the same scale. hs_drive is gated without a register.
module pgood_window_mon
    import pg_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_code,
    input  logic [SAMPLE_W-1:0] nom_code,
    input  logic                hs_req,
    output logic                pg_pull_low,
    output logic                ov_flag,
    output logic                hs_drive
);
    logic [NUM_THR-1:0][SAMPLE_W:0] thr;
    pg_cmp_t                        cmp;
    logic                           pg_good;
    logic                           ov_mask;

    pg_thresh_calc #(.SAMPLE_W(SAMPLE_W)) u_thr (
        .nom_code (nom_code),
        .thr      (thr)
    );

    pg_window_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .smp_code (smp_code),
        .thr      (thr),
        .cmp      (cmp)
    );

    pg_state_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .cmp     (cmp),
        .pg_good (pg_good),
        .ov_mask (ov_mask)
    );

    // Open-drain pull-down, mask flag and high-side gate
    always_comb begin
        pg_pull_low = !pg_good;
        ov_flag     = ov_mask;
        hs_drive    = hs_req && !ov_mask;
    end
endmodule

// File: rtl/pgood_window_mon_chk.sv
// Port-level properties of pgood_window_mon. Thresholds are recomputed here from the requirements.
module pgood_window_mon_chk #(
    parameter int unsigned SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_vld,
    input logic [SAMPLE_W-1:0] smp_code,
    input logic [SAMPLE_W-1:0] nom_code,
    input logic                hs_req,
    input logic                pg_pull_low,
    input logic                ov_flag,
    input logic                hs_drive
);
    localparam int unsigned W = SAMPLE_W + 8;
    logic [W-1:0] s, lf, lr, hr, hf;

    always_comb begin
        s  = W'(smp_code);
        lf = (W'(nom_code) * W'(92))  / W'(100);
        lr = (W'(nom_code) * W'(94))  / W'(100);
        hr = (W'(nom_code) * W'(107)) / W'(100);
        hf = (W'(nom_code) * W'(109)) / W'(100);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (pg_pull_low && !ov_flag));
    // R2
    uv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && s < lf) |=> pg_pull_low);
    // R3
    ov_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && s > hf) |=> (pg_pull_low && ov_flag));
    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && s >= lr && s <= hr) |=> !pg_pull_low);
    // R6
    ov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ov_flag) |-> $past(smp_vld && s < hr));
    // R7
    hs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |-> !hs_drive);
    // R7
    hs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drive |-> hs_req);
    // R8
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(pg_pull_low) && $stable(ov_flag)));
endmodule

bind pgood_window_mon pgood_window_mon_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_vld     (smp_vld),
    .smp_code    (smp_code),
    .nom_code    (nom_code),
    .hs_req      (hs_req),
    .pg_pull_low (pg_pull_low),
    .ov_flag     (ov_flag),
    .hs_drive    (hs_drive)
);

// File: tb/pgood_window_mon_test.sv
module pgood_window_mon_test;
    localparam int SW = 12;
    localparam int MAXC = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [SW-1:0] smp_code = '0;
    logic [SW-1:0] nom_code = '0;
    logic          hs_req = 1'b0;
    logic          pg_pull_low, ov_flag, hs_drive;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    bit  m_good = 1'b0;
    bit  m_ov = 1'b0;

    pgood_window_mon #(.SAMPLE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
        .nom_code(nom_code), .hs_req(hs_req), .pg_pull_low(pg_pull_low),
        .ov_flag(ov_flag), .hs_drive(hs_drive)
    );

    always #2 clk = ~clk;

    function automatic int pct(input int nom, input int p);
        return (nom * p) / 100;
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check gate, clock, update model, check state
    task automatic step(input bit vld, input int smp, input bit hs);
        string tpg, tov;
        int s, lf, lr, hr, hf;
        @(negedge clk);
        smp_vld = vld; smp_code = SW'(smp); hs_req = hs;
        #1;
        chk("R7", int'(hs_drive), int'(hs && !m_ov), "hs_drive");
        s = smp; lf = pct(nom_code, 92); lr = pct(nom_code, 94);
        hr = pct(nom_code, 107); hf = pct(nom_code, 109);
        tpg = "R8"; tov = "R8";
        if (vld) begin
            if (s > hf) begin tpg = "R3"; tov = "R3"; end
            else if (s < lf) tpg = "R2";
            else if (s >= lr && s <= hr) tpg = "R4";
            else tpg = "R5";
            if (tov != "R3") tov = (s < hr) ? "R6" : "R5";
            if (m_good) begin
                if (s < lf || s > hf) m_good = 1'b0;
            end else if (s >= lr && s <= hr) m_good = 1'b1;
            if (s > hf) m_ov = 1'b1;
            else if (s < hr) m_ov = 1'b0;
        end
        @(posedge clk);
        #1;
        chk(tpg, int'(pg_pull_low), int'(!m_good), "pg_pull_low");
        chk(tov, int'(ov_flag), int'(m_ov), "ov_flag");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        nom_code = SW'(1000);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(pg_pull_low), 1, "pg_pull_low in reset");
        chk("R1", int'(ov_flag), 0, "ov_flag in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", int'(pg_pull_low), 1, "pg_pull_low after reset");
        chk("R1", int'(ov_flag), 0, "ov_flag after reset");

        // Directed corners, nominal 1000: 920/940/1070/1090
        step(1, 939, 1);  // R5 hold fault
        step(1, 940, 1);  // R4 good
        step(0, 0, 1);    // R8 no strobe
        step(1, 920, 1);  // R5 still good
        step(1, 919, 1);  // R2 fault
        step(1, 1070, 0); // R4 inclusive upper
        step(1, 1090, 1); // R5 hold good, no ov
        step(1, 1091, 1); // R3 ov set
        step(0, 500, 1);  // R8 ov stays, hs blocked
        step(1, 1070, 1); // R6 not below 1070, stays
        step(1, 1069, 1); // R6 clears, R4 good
        step(1, 1080, 1); // R5 hold good
        step(1, 4095, 1); // R3 ov
        step(1, 0, 1);    // R2 + R6 clear

        // Random sweep around nominal
        for (int i = 0; i < 4000; i++) begin
            int s;
            if (i % 500 == 0) nom_code = SW'($urandom_range(200, 3700));
            s = pct(nom_code, int'($urandom_range(86, 114))) + int'($urandom_range(0, 4)) - 2;
            if (s < 0) s = 0;
            if (s > MAXC) s = MAXC;
            step(bit'($urandom_range(0, 3) != 0), s, bit'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule